// File: doc/BRIEF.md
# Byte-Wide Programmable Memory with Mode Decoder

This block is a synthesizable model of a byte-organised, electrically programmable read-only memory. A set of control inputs selects one of several modes. The controls are an active-low chip enable, an active-low output enable, a flag for programming voltage on the output-enable pin, and a flag for a high voltage on address bit 9. The programming voltage and the high voltage are each replaced by a single digital flag, so the block needs no analog levels. The data bus is split into an input byte `din` and an output byte `dout`. A separate `dout_en` flag stands in for tri-state pins.

Reads and the identifier readout are combinational. A program operation takes effect on the rising clock edge. It can only clear bits, because the new byte is ANDed into the stored one. An erase pulse starts a sequencer that writes FFh to one location per clock. While it runs, the sequencer holds `busy` high and keeps the memory closed to everything else.

The full device holds 65536 bytes (`ADDR_W` = 16). The default build uses a 1024-byte array so that elaboration stays small. The behaviour is the same at any width.

Top module: `byte_eprom`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0, `a9_hv`=0 and `busy`=0, `dout_en` is 1 and `dout` equals the byte stored at `addr` in the same cycle.
- R2: With `ce_n`=0, `oe_n`=1, `vpp_hi`=0 and `busy`=0 (output disable), `dout_en` is 0 and `stby` is 0.
- R3: With `ce_n`=1, `vpp_hi`=0 and `busy`=0 (standby), `stby` is 1 and `dout_en` is 0, whatever `oe_n`, `a9_hv`, `addr` and `din` are.
- R4: With `ce_n`=0, `vpp_hi`=1 and `busy`=0 (program), `dout_en` is 0 and `stby` is 0. At the next rising clock edge the byte at `addr` becomes its old value ANDed with `din`.
- R5: Programming never changes a stored bit from 0 to 1. Programming 5Ah over A5h leaves 00h.
- R6: With `ce_n`=1 and `vpp_hi`=1 (program inhibit), no location is written, `dout_en` is 0 and `stby` is 0.
- R7: Verify: once `vpp_hi` returns to 0 with `ce_n`=0 and `oe_n`=0, a location programmed in the previous cycle reads back its new value.
- R8: When `a9_hv`=1 under the read conditions of R1, `dout_en` is 1 and `dout` is 34h if `addr[0]`=0 and 1Fh if `addr[0]`=1, whatever the array holds.
- R9: `erase`=1 sampled at a rising edge while `busy`=0 raises `busy` from the next cycle for exactly 2^`ADDR_W` cycles. Afterwards every location reads FFh.
- R10: While `busy`=1, `dout_en` and `stby` are 0, program requests write nothing, and further `erase` pulses do not lengthen the busy window.
- R11: After synchronous reset `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and erase steps occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the erase sequencer |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present on the output-enable pin |
| a9_hv | input | 1 | Address bit 9 held at identifier-readout voltage |
| addr | input | ADDR_W | Byte address; bit 0 also picks the identifier byte |
| din | input | 8 | Byte to program |
| erase | input | 1 | Starts a whole-array erase to FFh |
| dout | output | 8 | Output byte, 00h when not driven |
| dout_en | output | 1 | High when the output byte is driven |
| stby | output | 1 | High in the low-power standby mode |
| busy | output | 1 | High while the erase sequencer runs |

## Verification
Every cycle, the assertions check the port-level mode gating. They confirm that the output is driven only under the read conditions, that standby and inhibit keep it undriven, and that the identifier byte matches `addr[0]`. They also check that no programmed bit ever rises and that busy rises only after an erase request. Only the bench scenarios can show that data actually lands. These scenarios cover the AND accumulation over successive programs, verify read-back, the exact length of the erase window, and the fact that a program or an erase issued during that window leaves no trace.

// File: rtl/byte_eprom_pkg.sv
package byte_eprom_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ID_MAKER = 8'h34;
    localparam logic [BYTE_W-1:0] ID_PART  = 8'h1F;
    localparam logic [BYTE_W-1:0] BLANK    = 8'hFF;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_PROGRAM,
        MD_DISABLE,
        MD_IDENT,
        MD_READ,
        MD_BUSY
    } mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic vpp_hi;
        logic a9_hv;
    } ctl_t;

    // Priority: erase in progress, then chip enable, then programming
    // voltage, then output enable, then identifier voltage.
    function automatic mode_e pick_mode(ctl_t c, logic busy);
        mode_e m;
        if (busy)          m = MD_BUSY;
        else if (c.ce_n)   m = c.vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (c.vpp_hi) m = MD_PROGRAM;
        else if (c.oe_n)   m = MD_DISABLE;
        else if (c.a9_hv)  m = MD_IDENT;
        else               m = MD_READ;
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] ident_byte(logic sel);
        return sel ? ID_PART : ID_MAKER;
    endfunction

endpackage

// File: rtl/ep_mode_dec.sv
module ep_mode_dec
    import byte_eprom_pkg::*;
(
    input  ctl_t  ctl,
    input  logic  busy,
    output mode_e mode,
    output logic  drive_en,
    output logic  stby,
    output logic  prog_we
);
    always_comb begin
        mode     = pick_mode(ctl, busy);
        drive_en = (mode == MD_READ) || (mode == MD_IDENT);
        stby     = (mode == MD_STANDBY);
        prog_we  = (mode == MD_PROGRAM);
    end
endmodule

// File: rtl/ep_erase_seq.sv
module ep_erase_seq #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_req,
    output logic              busy,
    output logic              clr_we,
    output logic [ADDR_W-1:0] clr_addr
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    logic [ADDR_W-1:0] step;
    logic              run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            step <= '0;
        end else if (run) begin
            if (step == LAST) run <= 1'b0;
            step <= step + 1'b1;
        end else if (erase_req) begin
            run  <= 1'b1;
            step <= '0;
        end
    end

    assign busy     = run;
    assign clr_we   = run;
    assign clr_addr = step;

    // R9: the sequencer starts only in answer to an erase request
    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(erase_req));

    // R10: a running erase does not stop before the last location
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && step != LAST) |=> busy);
endmodule

// File: rtl/ep_cell_array.sv
module ep_cell_array
    import byte_eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_we,
    input  logic [ADDR_W-1:0] clr_addr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_we)
            cells[clr_addr] <= BLANK;
        else if (prog_we)
            cells[addr] <= cells[addr] & wdata;
    end

    assign rdata = cells[addr];

    // R5: a program cycle never turns a 0 bit into a 1
    assert_no_bit_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (prog_we && !clr_we) |=>
            ((cells[$past(addr)] & ~$past(cells[addr])) == '0));
endmodule

// File: rtl/byte_eprom.sv
module byte_eprom
    import byte_eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              erase,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              stby,
    output logic              busy
);
    ctl_t              ctl;
    mode_e             mode;
    logic              drive_en, stby_i, prog_we, clr_we, busy_i;
    logic [ADDR_W-1:0] clr_addr;
    logic [BYTE_W-1:0] cell_q;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, vpp_hi: vpp_hi, a9_hv: a9_hv};

    ep_erase_seq #(.ADDR_W(ADDR_W)) u_erase (
        .clk(clk), .rst(rst), .erase_req(erase),
        .busy(busy_i), .clr_we(clr_we), .clr_addr(clr_addr)
    );

    ep_mode_dec u_dec (
        .ctl(ctl), .busy(busy_i), .mode(mode),
        .drive_en(drive_en), .stby(stby_i), .prog_we(prog_we)
    );

    ep_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk(clk), .rst(rst), .prog_we(prog_we), .addr(addr), .wdata(din),
        .clr_we(clr_we), .clr_addr(clr_addr), .rdata(cell_q)
    );

    always_comb begin
        unique case (mode)
            MD_IDENT: dout = ident_byte(addr[0]);
            MD_READ:  dout = cell_q;
            default:  dout = '0;
        endcase
    end

    assign dout_en = drive_en;
    assign stby    = stby_i;
    assign busy    = busy_i;

    // R1: the output is driven only under the read conditions
    assert_drive_gate_R1: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!ce_n && !oe_n && !vpp_hi && !busy));

    // R3: standby keeps the outputs undriven
    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !vpp_hi && !busy) |-> (stby && !dout_en));

    // R6: program inhibit neither drives nor sleeps
    assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_n && vpp_hi) |-> (!stby && !dout_en));

    // R8: identifier bytes follow address bit 0
    assert_ident_code_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ce_n && !oe_n && !vpp_hi && a9_hv) |->
            (dout_en && dout == (addr[0] ? 8'h1F : 8'h34)));
endmodule

// File: tb/sim_byte_eprom.sv
module sim_byte_eprom;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          erase = 1'b0;
    logic [7:0]    dout;
    logic          dout_en, stby, busy;

    always #2 clk = ~clk;   // 250 MHz

    byte_eprom #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .addr(addr), .din(din), .erase(erase),
        .dout(dout), .dout_en(dout_en), .stby(stby), .busy(busy)
    );

    typedef struct {
        logic       en;
        logic [7:0] data;
        logic       sb;
        logic       bz;
        string      req;
    } item_t;

    item_t q[$];
    int    applied = 0;
    int    miscmp  = 0;
    bit    done    = 0;

    logic [7:0] model [DEPTH];
    int         bleft = 0;

    // Monitor: outputs are combinational, compared mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            bit bad;
            it = q.pop_front();
            applied++;
            bad = (dout_en !== it.en) || (stby !== it.sb) || (busy !== it.bz) ||
                  (it.en && dout !== it.data);
            if (bad) begin
                miscmp++;
                $display("FAIL %s: en=%b d=%h sb=%b bz=%b expected en=%b d=%h sb=%b bz=%b",
                         it.req, dout_en, dout, stby, busy, it.en, it.data, it.sb, it.bz);
            end
        end
    end

    // Driver: applies one cycle of inputs and predicts the outputs
    task automatic step(input logic c, input logic o, input logic v, input logic h,
                        input int a, input logic [7:0] d, input logic e, input string req);
        item_t it;
        @(posedge clk);
        #1;
        ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h;
        addr = AW'(a); din = d; erase = e;
        it.req = req; it.en = 1'b0; it.data = 8'h00; it.sb = 1'b0;
        it.bz = (bleft > 0);
        if (bleft > 0) begin
        end else if (c) begin
            it.sb = !v;
        end else if (v) begin
            model[AW'(a)] = model[AW'(a)] & d;
        end else if (!o) begin
            it.en = 1'b1;
            it.data = h ? (a[0] ? 8'h1F : 8'h34) : model[AW'(a)];
        end
        q.push_back(it);
        if (bleft > 0) bleft--;
        else if (e) begin
            bleft = DEPTH;
            for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step(1, 0, 0, 1, 7, 8'h00, 0, "R11 R3 reset standby");

        // Erase, then probe the busy window
        step(1, 1, 0, 0, 0, 8'h00, 1, "R9 erase request");
        for (int k = 0; k < DEPTH; k++) begin
            if (k == 10)      step(0, 1, 1, 0, 5, 8'h00, 0, "R10 program during busy");
            else if (k == 20) step(1, 1, 0, 0, 0, 8'h00, 1, "R10 erase during busy");
            else              step(0, 0, 0, 0, k, 8'h00, 0, "R10 busy read blocked");
        end
        step(0, 0, 0, 0, 0, 8'h00, 0, "R9 blank low");
        step(0, 0, 0, 0, DEPTH - 1, 8'h00, 0, "R9 blank high");
        step(0, 0, 0, 0, 5, 8'h00, 0, "R10 blocked program left FF");
        step(0, 0, 0, 0, 21, 8'h00, 0, "R9 blank mid");

        // Program, verify, accumulate
        step(0, 1, 1, 0, 18, 8'hA5, 0, "R4 program A5");
        step(0, 0, 0, 0, 18, 8'h00, 0, "R7 verify A5");
        step(0, 1, 1, 0, 18, 8'h5A, 0, "R4 program 5A");
        step(0, 0, 0, 0, 18, 8'h00, 0, "R5 AND gives 00");
        step(0, 1, 1, 0, 19, 8'h0F, 0, "R4 program 0F");
        step(0, 1, 1, 0, 19, 8'hF3, 0, "R5 program F3");
        step(0, 0, 0, 0, 19, 8'h00, 0, "R5 AND gives 03");
        step(0, 0, 0, 0, 17, 8'h00, 0, "R1 neighbour untouched");

        // Output disable and inhibit
        step(0, 1, 0, 0, 18, 8'h00, 0, "R2 output disable");
        step(0, 1, 0, 1, 19, 8'h00, 0, "R2 disable with a9_hv");
        step(1, 0, 1, 0, 32, 8'h00, 0, "R6 inhibit");
        step(0, 0, 0, 0, 32, 8'h00, 0, "R6 inhibit wrote nothing");

        // Identifier readout
        step(0, 0, 0, 1, 18, 8'h00, 0, "R8 maker code");
        step(0, 0, 0, 1, 19, 8'h00, 0, "R8 part code");
        step(0, 0, 0, 1, DEPTH - 1, 8'h00, 0, "R8 part code high addr");
        step(0, 0, 0, 0, 19, 8'h00, 0, "R1 back to array");

        // Standby regardless of other inputs
        step(1, 0, 0, 1, 19, 8'h00, 0, "R3 standby ignores a9_hv");
        step(1, 1, 0, 0, 3, 8'hFF, 0, "R3 standby oe high");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
            $finish;
        end
    end
endmodule